// File: doc/BRIEF.md
# SCSI Host Adapter Command Front End

This block is the register-mapped command front end of a SCSI host adapter. A byte-wide register port lets software write configuration registers, push bytes into a 16-entry data FIFO and issue command codes. Command bytes go into a two-entry queue. A dispatcher takes one command per cycle from the head of that queue. The simple commands run at once. The select command is handed to an external bus sequencer through a one-cycle start strobe. The dispatcher then waits until the sequencer reports completion, along with interrupt bits and a step number.

The block keeps an interrupt status byte, and a single interrupt output is raised whenever any bit of that byte is set. Software reads the byte to clear it. A bus reset command drives the SCSI RST line high as a timed pulse of `RST_CYCLES` clocks. Whether it raises an interrupt depends on a mask bit in the first configuration register. After reset, the command register accepts only the no-op command until a no-op has been executed.

Top module: `scsi_cmd_front`

## Requirements
- R1: After reset or a device-reset command: clock factor reads 2, selection timeout 0, sync offset 0, destination 0, config-1 0x07, FIFO count 0, sequence step 0, interrupt status 0, status 0, and transfer-preset bytes at read addresses 10/11/12 read {CHIP_ID,16'h0} (bytes 0,0,CHIP_ID).
- R2: Write addresses are: 0 FIFO push, 1 command, 2 destination, 3 selection timeout, 4 sync offset, 5 clock factor, 6 config-1. Read addresses are: 0 FIFO pop, 1 status, 2 interrupt status, 3 sequence step, 4 FIFO count, 5 destination, 6 config-1, 7 clock factor, 8 selection timeout, 9 sync offset, and 10-12 preset; other addresses read 0. The destination keeps only wdata[2:0], and `dest_id` and `own_id` (config-1 bits [2:0]) drive the matching outputs.
- R3: The data FIFO returns bytes in write order and holds 16 bytes. A push when it is full is discarded and sets status bit 6, which stays set until a device reset. Popping an empty FIFO reads 0.
- R4: The command queue holds two entries. A command write made while the queue is full is dropped. Queued commands run in order, one per cycle, starting the cycle after the write, and only while no select is pending.
- R5: While the command register is blocked (after reset), writes of any nonzero command code are ignored. Executing no-op (0x00) removes the block.
- R6: A code other than 0x00-0x04 or 0x41 is removed from the queue and sets interrupt bit 6. DMA stop (0x04) has no visible effect.
- R7: Clear FIFO (0x01) empties the data FIFO in one cycle, and a push in the same cycle is lost.
- R8: Reset device (0x02) returns every register, both queues, the RST pulse and the pending select to the R1 values, and blocks the command register again.
- R9: Reset bus (0x03) drives `scsi_rst` high for exactly RST_CYCLES cycles starting the cycle after dispatch. It sets interrupt bit 7 only if config-1 bit 6 is clear.
- R10: Select (0x41) raises `seq_start` for the single cycle it is dispatched. On `seq_done` while pending, `seq_int` is ORed into the interrupt status, `seq_step_in` becomes the sequence step, and dispatch resumes.
- R11: `irq` is high exactly when the interrupt status is nonzero. Reading address 2 clears the status and the sequence step, but bits set in the same cycle survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO, clears interrupt status) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_addr |
| irq | output | 1 | Interrupt request |
| scsi_rst | output | 1 | SCSI bus RST drive |
| own_id | output | 3 | Adapter bus ID from config-1 |
| dest_id | output | 3 | Destination bus ID |
| seq_start | output | 1 | One-cycle select start strobe to the sequencer |
| seq_done | input | 1 | Sequencer completion strobe |
| seq_int | input | 8 | Interrupt bits reported by the sequencer |
| seq_step_in | input | 3 | Sequence step reported by the sequencer |

## Verification
The dispatcher is tried with command writes spread apart and with writes issued while a select is pending, which separates in-order queueing from the drop on a full queue. Nonzero codes written while the block is active test the post-reset blocking, and an invalid code read back in the very cycle its interrupt bit is set tests set-over-clear priority. Two bus resets, one with the mask bit clear and one with it set, check the pulse length and the masking. A device reset issued during a live pulse with a loaded FIFO shows that it restores everything.

// File: rtl/scmd_pkg.sv
package scmd_pkg;
  localparam logic [7:0] CMD_NOP     = 8'h00;
  localparam logic [7:0] CMD_FLUSH   = 8'h01;
  localparam logic [7:0] CMD_DEVRST  = 8'h02;
  localparam logic [7:0] CMD_BUSRST  = 8'h03;
  localparam logic [7:0] CMD_DMASTOP = 8'h04;
  localparam logic [7:0] CMD_SELECT  = 8'h41;

  localparam logic [3:0] WA_FIFO  = 4'd0;
  localparam logic [3:0] WA_CMD   = 4'd1;
  localparam logic [3:0] WA_DEST  = 4'd2;
  localparam logic [3:0] WA_SELTO = 4'd3;
  localparam logic [3:0] WA_SYNC  = 4'd4;
  localparam logic [3:0] WA_CLKF  = 4'd5;
  localparam logic [3:0] WA_CFG1  = 4'd6;

  localparam logic [3:0] RA_FIFO  = 4'd0;
  localparam logic [3:0] RA_STAT  = 4'd1;
  localparam logic [3:0] RA_INT   = 4'd2;
  localparam logic [3:0] RA_STEP  = 4'd3;
  localparam logic [3:0] RA_FCNT  = 4'd4;
  localparam logic [3:0] RA_DEST  = 4'd5;
  localparam logic [3:0] RA_CFG1  = 4'd6;
  localparam logic [3:0] RA_CLKF  = 4'd7;
  localparam logic [3:0] RA_SELTO = 4'd8;
  localparam logic [3:0] RA_SYNC  = 4'd9;
  localparam logic [3:0] RA_PRE0  = 4'd10;
  localparam logic [3:0] RA_PRE1  = 4'd11;
  localparam logic [3:0] RA_PRE2  = 4'd12;

  localparam int IB_BUSRST = 7;
  localparam int IB_BADCMD = 6;
  localparam int CFG1_NOINT = 6;

  function automatic logic [23:0] preset_of(input logic [7:0] id);
    return {id, 16'h0000};
  endfunction

  function automatic logic known_cmd(input logic [7:0] c);
    return (c <= CMD_DMASTOP) || (c == CMD_SELECT);
  endfunction
endpackage

// File: rtl/scmd_fifo.sv
module scmd_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wipe,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic          full, empty, do_push, do_pop, clr;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign clr     = flush || wipe;
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = empty ? '0 : mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; count <= '0; ovf <= 1'b0;
    end else if (clr) begin
      rp <= '0; wp <= '0; count <= '0;
      if (wipe) ovf <= 1'b0;
    end else begin
      if (do_push) wp <= adv(wp);
      if (do_pop)  rp <= adv(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
      if (push && full) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r3_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clr) |=> ovf);
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/scmd_cmdq.sv
module scmd_cmdq #(
  parameter int DEPTH = 2,
  parameter int W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  logic [W-1:0]  q  [DEPTH];
  logic [W-1:0]  qn [DEPTH];
  logic [CW-1:0] cnt, tgt;
  logic          full, do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign tgt     = do_pop ? cnt - 1'b1 : cnt;
  assign head    = q[0];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) qn[i] = q[i];
    if (do_pop)
      for (int i = 0; i < DEPTH - 1; i++) qn[i] = q[i+1];
    if (do_push)
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == tgt) qn[i] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else if (flush) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
      for (int i = 0; i < DEPTH; i++) q[i] <= qn[i];
    end
  end

  a_r4_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r4_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (cnt == CW'(DEPTH)));
endmodule

// File: rtl/scmd_rst_pulse.sv
module scmd_rst_pulse #(
  parameter int CYCLES = 2500,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clear,
  output logic active
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clear)           cnt <= '0;
    else if (fire)            cnt <= CW'(CYCLES);
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  a_r9_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clear) |=> active);
  a_r8_pulse_cut: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !active);
endmodule

// File: rtl/scsi_cmd_front.sv
module scsi_cmd_front #(
  parameter logic [7:0] CHIP_ID    = 8'h0C,
  parameter logic [7:0] CFG1_RST   = 8'h07,
  parameter int         RST_CYCLES = 2500,
  parameter int         DFIFO_DEPTH = 16,
  parameter int         CMDQ_DEPTH  = 2,
  localparam int        FCW = $clog2(DFIFO_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scsi_rst,
  output logic [2:0] own_id,
  output logic [2:0] dest_id,
  output logic       seq_start,
  input  logic       seq_done,
  input  logic [7:0] seq_int,
  input  logic [2:0] seq_step_in
);
  import scmd_pkg::*;

  logic [7:0] int_status, selto, sync_off, clkf, cfg1;
  logic [2:0] seq_step, dest;
  logic       blocked, busy;

  logic [7:0]     q_head, f_dout, int_set;
  logic           q_empty, cmd_wr, ex_go;
  logic           ex_nop, ex_flush, ex_devrst, ex_busrst, ex_sel, ex_bad;
  logic           int_clr, sel_fin, f_ovf;
  logic [FCW-1:0] f_count;
  logic [23:0]    preset;

  // dispatch events
  assign ex_go     = !busy && !q_empty;
  assign ex_nop    = ex_go && (q_head == CMD_NOP);
  assign ex_flush  = ex_go && (q_head == CMD_FLUSH);
  assign ex_devrst = ex_go && (q_head == CMD_DEVRST);
  assign ex_busrst = ex_go && (q_head == CMD_BUSRST);
  assign ex_sel    = ex_go && (q_head == CMD_SELECT);
  assign ex_bad    = ex_go && !known_cmd(q_head);
  assign sel_fin   = busy && seq_done;
  assign seq_start = ex_sel;

  assign cmd_wr  = reg_wr && (reg_addr == WA_CMD) && (!blocked || reg_wdata == CMD_NOP);
  assign int_clr = reg_rd && (reg_addr == RA_INT);
  assign int_set = ({8{ex_busrst && !cfg1[CFG1_NOINT]}} & (8'h1 << IB_BUSRST))
                 | ({8{ex_bad}} & (8'h1 << IB_BADCMD))
                 | ({8{sel_fin}} & seq_int);

  scmd_cmdq #(.DEPTH(CMDQ_DEPTH), .W(8)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .flush(ex_devrst), .push(cmd_wr),
    .din(reg_wdata), .pop(ex_go), .head(q_head), .empty(q_empty));

  scmd_fifo #(.DEPTH(DFIFO_DEPTH), .W(8)) u_dfifo (
    .clk(clk), .rst_n(rst_n), .flush(ex_flush), .wipe(ex_devrst),
    .push(reg_wr && reg_addr == WA_FIFO), .din(reg_wdata),
    .pop(reg_rd && reg_addr == RA_FIFO), .dout(f_dout),
    .count(f_count), .ovf(f_ovf));

  scmd_rst_pulse #(.CYCLES(RST_CYCLES)) u_rstp (
    .clk(clk), .rst_n(rst_n), .fire(ex_busrst), .clear(ex_devrst), .active(scsi_rst));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_status <= '0; seq_step <= '0; blocked <= 1'b1; busy <= 1'b0;
      dest <= '0; selto <= '0; sync_off <= '0; clkf <= 8'd2; cfg1 <= CFG1_RST;
    end else if (ex_devrst) begin
      int_status <= '0; seq_step <= '0; blocked <= 1'b1; busy <= 1'b0;
      dest <= '0; selto <= '0; sync_off <= '0; clkf <= 8'd2; cfg1 <= CFG1_RST;
    end else begin
      int_status <= (int_clr ? 8'h00 : int_status) | int_set;
      if (sel_fin)      seq_step <= seq_step_in;
      else if (int_clr) seq_step <= '0;
      if (ex_nop) blocked <= 1'b0;
      if (ex_sel) busy <= 1'b1;
      else if (sel_fin) busy <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          WA_DEST:  dest     <= reg_wdata[2:0];
          WA_SELTO: selto    <= reg_wdata;
          WA_SYNC:  sync_off <= reg_wdata;
          WA_CLKF:  clkf     <= reg_wdata;
          WA_CFG1:  cfg1     <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  assign preset  = preset_of(CHIP_ID);
  assign irq     = (int_status != 8'h00);
  assign own_id  = cfg1[2:0];
  assign dest_id = dest;

  always_comb begin
    case (reg_addr)
      RA_FIFO:  reg_rdata = f_dout;
      RA_STAT:  reg_rdata = {1'b0, f_ovf, 6'b0};
      RA_INT:   reg_rdata = int_status;
      RA_STEP:  reg_rdata = {5'b0, seq_step};
      RA_FCNT:  reg_rdata = 8'(f_count);
      RA_DEST:  reg_rdata = {5'b0, dest};
      RA_CFG1:  reg_rdata = cfg1;
      RA_CLKF:  reg_rdata = clkf;
      RA_SELTO: reg_rdata = selto;
      RA_SYNC:  reg_rdata = sync_off;
      RA_PRE0:  reg_rdata = preset[7:0];
      RA_PRE1:  reg_rdata = preset[15:8];
      RA_PRE2:  reg_rdata = preset[23:16];
      default:  reg_rdata = 8'h00;
    endcase
  end

  a_r10_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);
  a_r6_badcmd_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bad |=> int_status[IB_BADCMD]);
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clr && int_set == 8'h00) |=> !irq);
  a_r5_block_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !ex_nop && !ex_devrst) |=> blocked);
endmodule

// File: tb/scsi_cmd_front_test.sv
`timescale 1ns/1ps
module scsi_cmd_front_test;
  localparam int RSTC = 300;
  localparam logic [7:0] CHIP = 8'h0C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, seq_done = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, seq_int = 0;
  logic [2:0] seq_step_in = 0;
  logic [7:0] reg_rdata;
  logic irq, scsi_rst, seq_start;
  logic [2:0] own_id, dest_id;

  always #5 clk = ~clk;

  scsi_cmd_front #(.CHIP_ID(CHIP), .RST_CYCLES(RSTC)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .scsi_rst(scsi_rst), .own_id(own_id), .dest_id(dest_id),
    .seq_start(seq_start), .seq_done(seq_done), .seq_int(seq_int),
    .seq_step_in(seq_step_in));

  // behavioural reference model
  logic [7:0] mq[$];
  logic [7:0] mf[$];
  int m_int, m_step, m_blk, m_busy, m_dest, m_selto, m_sync, m_clkf, m_cfg1, m_ovf, m_rc;
  int vectors = 0, bad = 0;
  string cur_req = "R1";

  task automatic m_reset();
    mq.delete(); mf.delete();
    m_int = 0; m_step = 0; m_blk = 1; m_busy = 0; m_dest = 0; m_selto = 0;
    m_sync = 0; m_clkf = 2; m_cfg1 = 7; m_ovf = 0; m_rc = 0;
  endtask

  task automatic m_step_clk();
    bit ex, clr, cmdw, qfull;
    logic [7:0] code;
    int set;
    ex = (m_busy == 0) && (mq.size() > 0);
    code = ex ? mq[0] : 8'h00;
    clr = reg_rd && reg_addr == 4'd2;
    cmdw = reg_wr && reg_addr == 4'd1 && (m_blk == 0 || reg_wdata == 8'h00);
    qfull = mq.size() >= 2;
    if (ex && code == 8'h02) begin
      m_reset();
      return;
    end
    set = 0;
    if (m_rc > 0) m_rc--;
    if (m_busy != 0 && seq_done) begin
      set |= seq_int; m_step = seq_step_in; m_busy = 0;
    end else if (clr) m_step = 0;
    if (ex) begin
      case (code)
        8'h00: m_blk = 0;
        8'h01: ;
        8'h03: begin m_rc = RSTC; if ((m_cfg1 & 8'h40) == 0) set |= 8'h80; end
        8'h04: ;
        8'h41: m_busy = 1;
        default: set |= 8'h40;
      endcase
      void'(mq.pop_front());
    end
    m_int = (clr ? 0 : m_int) | set;
    if (cmdw && !qfull) mq.push_back(reg_wdata);
    if (ex && code == 8'h01) mf.delete();
    else begin
      bit ffull = mf.size() >= 16;
      if (reg_rd && reg_addr == 4'd0 && mf.size() > 0) void'(mf.pop_front());
      if (reg_wr && reg_addr == 4'd0) begin
        if (ffull) m_ovf = 1; else mf.push_back(reg_wdata);
      end
    end
    if (reg_wr) case (reg_addr)
      4'd2: m_dest = reg_wdata & 7;
      4'd3: m_selto = reg_wdata;
      4'd4: m_sync = reg_wdata;
      4'd5: m_clkf = reg_wdata;
      4'd6: m_cfg1 = reg_wdata;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset(); else m_step_clk();
  end

  function automatic logic [7:0] m_rdata();
    case (reg_addr)
      4'd0: return mf.size() > 0 ? mf[0] : 8'h00;
      4'd1: return m_ovf ? 8'h40 : 8'h00;
      4'd2: return 8'(m_int);
      4'd3: return 8'(m_step);
      4'd4: return 8'(mf.size());
      4'd5: return 8'(m_dest);
      4'd6: return 8'(m_cfg1);
      4'd7: return 8'(m_clkf);
      4'd8: return 8'(m_selto);
      4'd9: return 8'(m_sync);
      4'd12: return CHIP;
      default: return 8'h00;
    endcase
  endfunction

  task automatic cmp(string nm, int act, int exp);
    if (act != exp) begin
      $display("FAIL %s %s act=%0h exp=%0h at %0t", cur_req, nm, act, exp, $time);
      bad++;
    end
  endtask

  // one clock: drive at negedge, compare 4 ns later, before the rising edge
  task automatic cyc(input logic wr, input logic rd, input logic [3:0] a, input logic [7:0] d);
    int b0;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    #4;
    b0 = bad;
    vectors++;
    cmp("rdata", reg_rdata, m_rdata());
    cmp("irq", irq, m_int != 0);
    cmp("scsi_rst", scsi_rst, m_rc != 0);
    cmp("seq_start", seq_start, (m_busy == 0 && mq.size() > 0 && mq[0] == 8'h41));
    cmp("own_id", own_id, m_cfg1 & 7);
    cmp("dest_id", dest_id, m_dest);
    if (bad > b0) bad = b0 + 1;
    @(negedge clk);
    seq_done = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 4'd1, 0);
  endtask
  task automatic rd(logic [3:0] a);  cyc(0, 1, a, 0); endtask
  task automatic peek(logic [3:0] a); cyc(0, 0, a, 0); endtask
  task automatic wr(logic [3:0] a, logic [7:0] d); cyc(1, 0, a, d); endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values visible through every read address
    cur_req = "R1";
    for (int a = 0; a < 16; a++) peek(4'(a));
    // R5: nonzero command ignored while blocked (FIFO keeps its byte)
    cur_req = "R5";
    wr(4'd0, 8'hA5); wr(4'd1, 8'h01); idle(2); peek(4'd4);
    wr(4'd1, 8'h55); idle(2); peek(4'd2);
    wr(4'd1, 8'h00); idle(2);
    wr(4'd1, 8'h01); idle(1); peek(4'd4);
    // R2: register decode, destination keeps 3 bits, own id from config-1
    cur_req = "R2";
    wr(4'd2, 8'hFD); wr(4'd3, 8'h93); wr(4'd4, 8'h0F); wr(4'd5, 8'h05); wr(4'd6, 8'h03);
    for (int a = 0; a < 16; a++) peek(4'(a));
    // R3: fill past 16, overflow flag, FIFO order, empty read
    cur_req = "R3";
    for (int i = 0; i < 17; i++) wr(4'd0, 8'(8'h10 + i));
    peek(4'd1); peek(4'd4);
    for (int i = 0; i < 18; i++) rd(4'd0);
    peek(4'd1);
    // R7: clear FIFO, with a push in the dispatch cycle
    cur_req = "R7";
    for (int i = 0; i < 3; i++) wr(4'd0, 8'(8'h30 + i));
    wr(4'd1, 8'h01); wr(4'd0, 8'hEE); peek(4'd4); rd(4'd0);
    // R10 + R4: select pending, three commands queued, third dropped
    cur_req = "R10";
    wr(4'd0, 8'h77); wr(4'd1, 8'h41); idle(3);
    cur_req = "R4";
    wr(4'd1, 8'h04); wr(4'd1, 8'h55); wr(4'd1, 8'h01); idle(2); peek(4'd4);
    cur_req = "R10";
    seq_int = 8'h18; seq_step_in = 3'd4; seq_done = 1; peek(4'd2);
    peek(4'd3); idle(3); peek(4'd4);
    // R11: read clears status and step; R6 bit set in same cycle as clear
    cur_req = "R11";
    rd(4'd2); peek(4'd3); peek(4'd2);
    cur_req = "R6";
    wr(4'd1, 8'h7E); rd(4'd2); peek(4'd2); rd(4'd2); peek(4'd2);
    wr(4'd1, 8'h04); idle(2); peek(4'd2);
    // R9: bus reset pulse, interrupt unmasked then masked
    cur_req = "R9";
    wr(4'd1, 8'h03); idle(RSTC + 4); peek(4'd2); rd(4'd2);
    wr(4'd6, 8'h47); wr(4'd1, 8'h03); idle(RSTC + 4); peek(4'd2);
    // R8: device reset during a pulse with loaded FIFO and overflow
    cur_req = "R8";
    for (int i = 0; i < 17; i++) wr(4'd0, 8'(i));
    wr(4'd1, 8'h03); idle(20);
    wr(4'd1, 8'h02); idle(2);
    for (int a = 0; a < 16; a++) peek(4'(a));
    wr(4'd1, 8'h03); idle(3);
    cur_req = "R5";
    wr(4'd1, 8'h00); idle(1); wr(4'd1, 8'h03); idle(RSTC + 3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule